// File: doc/BRIEF.md
# Asynchronous Bus Write Responder

This block sits on the memory side of a 16-bit asynchronous bus and answers write cycles from a bus master. It watches the address strobe and the data strobe, both active low, through a two-flop synchronizer. When both are seen asserted on a qualifying write, it stores the selected byte lanes of the data bus into a small word-wide register file. It then asserts its port-size acknowledge. It keeps the acknowledge until the first of the two strobes is seen negated, and then withdraws it.

Which lanes are written depends on the transfer size code and on address bit 0. Cycles flagged as processor-internal space by the space code, and all read cycles, are never acknowledged and never touch storage. A programmable wait count holds the acknowledge back by 0 to 7 extra clocks, so that the master's wait-state path can be exercised. A side read port with a word index lets the rest of the chip see the stored words.

Top module: `async_wr_responder`

## Requirements
- R1: After reset both acknowledge outputs are high (negated) and every stored word reads 0x0000.
- R2: A write with xfer_size = 2'b01 (byte) and bus_addr[0] = 0 replaces bits 15:8 of the indexed word with bus_data[15:8] and leaves bits 7:0 unchanged.
- R3: A byte write (xfer_size = 2'b01) with bus_addr[0] = 1 replaces bits 7:0 of the indexed word with bus_data[7:0] and leaves bits 15:8 unchanged.
- R4: Any other size code writes both lanes when bus_addr[0] = 0, and only bits 7:0 when bus_addr[0] = 1. The word index is bus_addr[IDX_W:1].
- R5: The block answers as a 16-bit port: ack_hi_n goes low to acknowledge, and ack_lo_n stays high at all times.
- R6: On an accepted write, the store and the fall of ack_hi_n happen on the (wait_cfg + 4)-th rising clock edge after both strobes go low.
- R7: ack_hi_n stays low while both strobes stay low. It returns high on the third rising edge after the first of the two strobes negates, whether that is the address strobe or the data strobe.
- R8: A cycle with space_code = 4'd7 gets no acknowledge and changes no stored word.
- R9: A read cycle (rd_wr = 1) gets no acknowledge and changes no stored word.
- R10: A new cycle is accepted only after both strobes have been seen negated. A data strobe that is reasserted while the address strobe stays low gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strb_n | input | 1 | Address strobe, active low |
| data_strb_n | input | 1 | Data strobe, active low |
| rd_wr | input | 1 | 1 for a read, 0 for a write |
| xfer_size | input | 2 | Transfer size code, 2'b01 is a byte |
| bus_addr | input | IDX_W+1 | Bit 0 picks the lane; the upper bits are the word index |
| space_code | input | 4 | Address space code; 7 is processor space |
| bus_data | input | 16 | Write data, upper and lower lanes |
| wait_cfg | input | WAIT_W | Extra clocks before the acknowledge |
| ack_hi_n | output | 1 | Acknowledge for a 16-bit port, active low |
| ack_lo_n | output | 1 | Second acknowledge line, held high |
| rd_idx | input | IDX_W | Storage read index |
| rd_word | output | 16 | Stored word at rd_idx |

## Verification
The bench aims at the release path first. It negates the data strobe alone and the address strobe alone. A design that waited for both strobes, or for only one fixed strobe, would hold the acknowledge too long and stall the master. Wait counts 0, 3 and 7 are timed to the exact edge: an off-by-one counter moves the acknowledge and the store by one clock. It also reasserts the data strobe under a held address strobe, and a design with no end state would acknowledge a phantom second cycle. Odd-address non-byte writes, processor-space cycles and reads are each followed by a read-back of the storage. Such a read-back exposes wrong lane masks and stores that should have been suppressed.

// File: rtl/async_wr_pkg.sv
package async_wr_pkg;
  localparam int LANE_W = 8;
  localparam logic [1:0] SIZE_BYTE = 2'b01;
  localparam logic [3:0] SPACE_PROC = 4'd7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2,
    ST_END  = 2'd3
  } bus_st_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } lane_sel_t;
endpackage

// File: rtl/async_wr_sync.sv
module async_wr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], d_in[b]};
    end
    assign d_out[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/async_wr_lanes.sv
module async_wr_lanes
  import async_wr_pkg::*;
(
  input  logic [1:0] size_code,
  input  logic       addr_lsb,
  output lane_sel_t  lanes
);
  always_comb begin
    if (size_code == SIZE_BYTE) begin
      lanes.hi = ~addr_lsb;
      lanes.lo = addr_lsb;
    end else begin
      lanes.hi = ~addr_lsb;
      lanes.lo = 1'b1;
    end
  end

  // R4: every cycle selects at least one lane
  always_comb begin
    assert_lane_nonempty_R4: assert (lanes.hi | lanes.lo);
  end
endmodule

// File: rtl/async_wr_store.sv
module async_wr_store
  import async_wr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  lane_sel_t         wr_lanes,
  input  logic [2*LANE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [2*LANE_W-1:0] rd_data
);
  logic [LANE_W-1:0] mem_q [DEPTH][2];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    for (genvar l = 0; l < 2; l++) begin : g_lane
      logic lane_en;
      assign lane_en = wr_en && (wr_idx == IDX_W'(e)) &&
                       ((l == 1) ? wr_lanes.hi : wr_lanes.lo);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mem_q[e][l] <= '0;
        else if (lane_en) mem_q[e][l] <= wr_data[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_data = {mem_q[rd_idx][1], mem_q[rd_idx][0]};
endmodule

// File: rtl/async_wr_ctrl.sv
module async_wr_ctrl
  import async_wr_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_sync_n,
  input  logic              ds_sync_n,
  input  logic              qualify,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic              wr_en,
  output logic              ack_on
);
  bus_st_e           st_q, st_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;
  logic              both_low, both_high;

  assign both_low  = ~as_sync_n & ~ds_sync_n;
  assign both_high = as_sync_n & ds_sync_n;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    wr_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (both_low) begin
        if (qualify) begin
          st_d   = ST_WAIT;
          cnt_d  = wait_cfg;
          cnt_en = 1'b1;
        end else begin
          st_d = ST_END;
        end
      end
      ST_WAIT: begin
        if (!both_low) begin
          st_d = ST_END;
        end else if (cnt_q == '0) begin
          st_d  = ST_ACK;
          wr_en = 1'b1;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_ACK:  if (!both_low) st_d = ST_END;
      ST_END:  if (both_high) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ack_on = (st_q == ST_ACK);

  // R6: acknowledge rises only right after a store
  assert_ack_after_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_on) |-> $past(wr_en));
  // R7: acknowledge only while both strobes were held
  assert_ack_needs_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_on |-> $past(both_low));
  // R7: strobe negation drops the acknowledge next edge
  assert_ack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_on && !both_low) |=> !ack_on);
  // R10: leaving the end state requires both strobes negated
  assert_end_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_END && !both_high) |=> st_q == ST_END);
endmodule

// File: rtl/async_wr_responder.sv
module async_wr_responder
  import async_wr_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int WAIT_W = 3,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addr_strb_n,
  input  logic                data_strb_n,
  input  logic                rd_wr,
  input  logic [1:0]          xfer_size,
  input  logic [IDX_W:0]      bus_addr,
  input  logic [3:0]          space_code,
  input  logic [2*LANE_W-1:0] bus_data,
  input  logic [WAIT_W-1:0]   wait_cfg,
  output logic                ack_hi_n,
  output logic                ack_lo_n,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [2*LANE_W-1:0] rd_word
);
  logic       rst_meta_q, rst_sync_n;
  logic [1:0] strb_sync;
  logic       qualify, wr_en, ack_on;
  lane_sel_t  lanes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  async_wr_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_in  ({addr_strb_n, data_strb_n}),
    .d_out (strb_sync)
  );

  assign qualify = ~rd_wr && (space_code != SPACE_PROC);

  async_wr_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .as_sync_n (strb_sync[1]),
    .ds_sync_n (strb_sync[0]),
    .qualify   (qualify),
    .wait_cfg  (wait_cfg),
    .wr_en     (wr_en),
    .ack_on    (ack_on)
  );

  async_wr_lanes u_lanes (
    .size_code (xfer_size),
    .addr_lsb  (bus_addr[0]),
    .lanes     (lanes)
  );

  async_wr_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_idx   (bus_addr[IDX_W:1]),
    .wr_lanes (lanes),
    .wr_data  (bus_data),
    .rd_idx   (rd_idx),
    .rd_data  (rd_word)
  );

  assign ack_hi_n = ~ack_on;
  assign ack_lo_n = 1'b1;

  // R8: processor-space cycles never store
  assert_no_proc_store_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> space_code != SPACE_PROC);
  // R9: reads never store
  assert_no_read_store_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> !rd_wr);
endmodule

// File: tb/async_wr_responder_tb.sv
module async_wr_responder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic as_n = 1'b1, ds_n = 1'b1, rd_wr = 1'b0;
  logic [1:0] xsz = 2'b10;
  logic [IDX_W:0] addr = '0;
  logic [3:0] sp = 4'd1;
  logic [15:0] dat = '0;
  logic [2:0] wcfg = '0;
  logic ack_hi_n, ack_lo_n;
  logic [IDX_W-1:0] rd_idx = '0;
  logic [15:0] rd_word;

  int n_chk = 0, n_bad = 0;
  bit drv_done = 0;
  logic [15:0] model [DEPTH];
  int idx_q[$];
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  async_wr_responder #(.DEPTH(DEPTH), .WAIT_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_strb_n(as_n), .data_strb_n(ds_n),
    .rd_wr(rd_wr), .xfer_size(xsz), .bus_addr(addr), .space_code(sp),
    .bus_data(dat), .wait_cfg(wcfg), .ack_hi_n(ack_hi_n), .ack_lo_n(ack_lo_n),
    .rd_idx(rd_idx), .rd_word(rd_word)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int idx, input string tag);
    idx_q.push_back(idx);
    exp_q.push_back(model[idx]);
    tag_q.push_back(tag);
  endtask

  // One bus cycle; ds_first picks which strobe is negated first
  task automatic bus_cycle(input int idx, input bit a0, input logic [1:0] sz,
                           input logic [15:0] d, input int wt, input logic [3:0] spc,
                           input bit rdwr, input bit ds_first, input string tag);
    bit exp_ack;
    int n;
    exp_ack = !rdwr && (spc != 4'd7);
    @(negedge clk);
    addr = {IDX_W'(idx), a0}; xsz = sz; dat = d; wcfg = 3'(wt);
    sp = spc; rd_wr = rdwr;
    as_n = 1'b0; ds_n = 1'b0;
    if (exp_ack) begin
      n = 0;
      do begin @(negedge clk); n++; end while (ack_hi_n && n < 20);
      chk(n == wt + 4, {tag, " R6 ack latency"}, n, wt + 4);
      chk(ack_lo_n == 1'b1, {tag, " R5 low ack line"}, ack_lo_n, 1);
      repeat (2) @(negedge clk);
      chk(ack_hi_n == 1'b0, {tag, " R7 ack held"}, ack_hi_n, 0);
      if (ds_first) ds_n = 1'b1; else as_n = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (!ack_hi_n && n < 20);
      chk(n == 3, {tag, " R7 release edge"}, n, 3);
      if (!ack_hi_n) ; // nothing
      if (!rdwr) begin
        if (!a0) model[idx][15:8] = d[15:8];
        if (a0 || sz != 2'b01) model[idx][7:0] = d[7:0];
      end
    end else begin
      n = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (!ack_hi_n) n++;
      end
      chk(n == 0, {tag, " no ack"}, n, 0);
    end
    as_n = 1'b1; ds_n = 1'b1;
    repeat (4) @(negedge clk);
    push(idx, tag);
  endtask

  // Scoreboard monitor: owns the storage read port
  initial begin
    forever begin
      wait (idx_q.size() > 0);
      @(negedge clk);
      begin
        int i;
        logic [15:0] e;
        string t;
        i = idx_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        rd_idx = IDX_W'(i);
        #1;
        chk(rd_word === e, {t, " stored word"}, rd_word, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ack_hi_n == 1'b1, "R1 reset ack_hi_n", ack_hi_n, 1);
    chk(ack_lo_n == 1'b1, "R1 reset ack_lo_n", ack_lo_n, 1);
    for (int i = 0; i < DEPTH; i++) push(i, "R1 reset storage");
    wait (idx_q.size() == 0);

    bus_cycle(0, 1'b0, 2'b10, 16'hA1B2, 0, 4'd5, 0, 1, "R4 word even");
    bus_cycle(0, 1'b0, 2'b01, 16'h3C4D, 3, 4'd1, 0, 0, "R2 byte upper");
    bus_cycle(0, 1'b1, 2'b01, 16'h5E6F, 7, 4'd2, 0, 1, "R3 byte lower");
    bus_cycle(3, 1'b1, 2'b00, 16'h7788, 1, 4'd5, 0, 0, "R4 odd non-byte");
    bus_cycle(5, 1'b0, 2'b11, 16'h99AA, 2, 4'd6, 0, 1, "R4 three-byte even");
    bus_cycle(7, 1'b0, 2'b10, 16'hFFEE, 5, 4'd1, 0, 0, "R6 wait five");
    bus_cycle(0, 1'b0, 2'b10, 16'h1234, 0, 4'd7, 0, 1, "R8 proc space");
    bus_cycle(7, 1'b1, 2'b01, 16'h5678, 2, 4'd7, 0, 0, "R8 proc byte");
    bus_cycle(3, 1'b0, 2'b10, 16'hDEAD, 0, 4'd5, 1, 1, "R9 read");

    // R10: ds reasserted under a held address strobe
    @(negedge clk);
    addr = {IDX_W'(2), 1'b0}; xsz = 2'b10; dat = 16'hCAFE; wcfg = '0;
    sp = 4'd5; rd_wr = 1'b0; as_n = 1'b0; ds_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(ack_hi_n == 1'b0, "R10 first ack", ack_hi_n, 0);
    model[2] = 16'hCAFE;
    ds_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ack_hi_n == 1'b1, "R7 ds-only release", ack_hi_n, 1);
    dat = 16'hBEEF; ds_n = 1'b0;
    begin
      int n;
      n = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (!ack_hi_n) n++;
      end
      chk(n == 0, "R10 no phantom ack", n, 0);
    end
    as_n = 1'b1; ds_n = 1'b1;
    repeat (4) @(negedge clk);
    push(2, "R10 storage after phantom");
    bus_cycle(2, 1'b1, 2'b01, 16'h0042, 4, 4'd1, 0, 0, "R10 next cycle ok");

    wait (idx_q.size() == 0);
    repeat (2) @(negedge clk);
    drv_done = 1;
  end

  initial begin
    fork
      wait (drv_done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule